// File: doc/BRIEF.md
# Unified Translation Buffer with Rotating Fill Pointer

This block holds a fully associative set of translation entries shared by data and instruction fetch. Each entry keeps a virtual page tag, an address-space tag, a physical page, a nine-bit flag word and a four-bit attribute nibble. The page size comes from two flag bits and is decoded into a compare mask when the entry is looked up. A lookup returns the single matching entry, a miss, or a multi-hit when two or more entries match. The caller chooses per lookup whether the address-space tag takes part in the match.

Software fills the buffer in two ways. It can stage a tag word, a page word and an attribute nibble, then issue a load command that copies them into the slot named by a rotating fill pointer. Or it can reach the arrays directly through a memory-mapped window. In that window, one address bit turns a tag write into an associative update of the valid and dirty bits. A control word holds the fill pointer, its software-set wrap boundary and a six-bit recency word kept for the neighbouring instruction buffer. Writing the control word can also invalidate every entry at once.

The fill pointer advances on every lookup, whatever the outcome. Software therefore sees a cheap pseudo-random victim each time it takes a miss.

Top module: `xlat_utlb`

## Requirements
- R1: After reset, all four registers read 0, every lookup misses, and every tag word of the array reads 0.
- R2: Each lookup adds one to the fill pointer at the clock edge that ends it, whether it hits, misses or multi-hits; the pointer is read back in control bits 15:10.
- R3: When the incremented pointer equals the boundary (control bits 23:18) or reaches 64, the pointer becomes 0 instead; a boundary of 0 wraps only at 64.
- R4: With address-space checking on, an entry matches when its valid flag (0x100) is set, its shared flag (0x002) is set or its address-space tag equals staged tag bits 7:0, and the address agrees with the entry's page tag above the page offset. Flag bits 7 and 4 give the offset width: 00 means 10 bits, 01 means 12, 10 means 16 and 11 means 20. On a single match the block presents the index, the physical page (bits 28:10), the flags and the attribute nibble.
- R5: With address-space checking off, the address-space tag and the shared flag are ignored.
- R6: Two or more matching entries raise the multi-hit output and not the hit output; exactly one of hit, miss and multi-hit is high during a lookup.
- R7: The load command writes the page tag (staged bits 31:10), address-space tag (staged bits 7:0), physical page, flags (page word bits 8:0) and attribute nibble into the slot at the fill pointer, and leaves the pointer unchanged.
- R8: A tag-array write with address bit 7 clear targets the entry at address bits 13:8; it sets the page tag from data bits 31:10, the address-space tag from 7:0, valid from bit 8 and dirty (flag 0x004) from bit 9. Reading a tag word returns page tag, dirty at bit 9, valid at bit 8 and address-space tag in bits 7:0.
- R9: A tag-array write with address bit 7 set matches using the staged address-space tag and ignores valid flags; on exactly one match it copies data bit 8 into valid and bit 9 into dirty; on no match nothing changes.
- R10: When that associative write finds two or more matches, the collision output is high in that cycle and no entry changes.
- R11: On the data array, address bit 23 set reads and writes the attribute nibble in bits 3:0; clear, it reads and writes physical page bits 28:10 and flags bits 8:0, with bit 9 read as 0.
- R12: A control write loads the pointer from bits 15:10, the boundary from 23:18, the recency word from 31:26 and keeps bits 0, 8 and 9; reading returns them in the same places. Bit 2 of the write data invalidates every entry.
- R13: The staged tag word discards bits 9:8, the staged page word keeps only bits 28:10 and 8:0, and the attribute register keeps bits 3:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lk_valid | input | 1 | Lookup request for this cycle |
| lk_addr | input | 32 | Virtual address to look up |
| lk_asid_chk | input | 1 | Include the address-space tag in the match |
| lk_hit | output | 1 | Exactly one entry matched |
| lk_miss | output | 1 | No entry matched |
| lk_multi | output | 1 | Two or more entries matched |
| lk_index | output | 6 | Index of the matching entry |
| lk_ppn | output | 32 | Physical page of the match, bits 28:10 |
| lk_flags | output | 9 | Flag word of the match |
| lk_attr | output | 4 | Attribute nibble of the match |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | 0 staged tag, 1 staged page, 2 attribute, 3 control |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Selected register contents |
| ld_entry | input | 1 | Load staged values at the fill pointer |
| arr_en | input | 1 | Array window access |
| arr_we | input | 1 | Array window write |
| arr_sel | input | 1 | 0 tag array, 1 data array |
| arr_addr | input | 32 | Array window address |
| arr_wdata | input | 32 | Array write data |
| arr_rdata | output | 32 | Array read data |
| assoc_multi | output | 1 | Associative write found several matches |

## Verification
A fill pointer that steps wrongly shows in the control readback after the very next lookup, and again at the next load command, which writes a slot other than the one software expected. A flag or mask held wrongly shows at the next lookup of that page, either as a hit where a miss was due or as a wrong index. A corrupted tag shows when that slot is read through the array window. The random phase mixes lookups with writes of every kind, so a wrong state shows within a few operations.

// File: rtl/xlat_utlb.sv
module xlat_utlb #(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_valid,
  input  logic [31:0]      lk_addr,
  input  logic             lk_asid_chk,
  output logic             lk_hit,
  output logic             lk_miss,
  output logic             lk_multi,
  output logic [IDX_W-1:0] lk_index,
  output logic [31:0]      lk_ppn,
  output logic [8:0]       lk_flags,
  output logic [3:0]       lk_attr,
  input  logic             reg_we,
  input  logic [1:0]       reg_sel,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic             ld_entry,
  input  logic             arr_en,
  input  logic             arr_we,
  input  logic             arr_sel,
  input  logic [31:0]      arr_addr,
  input  logic [31:0]      arr_wdata,
  output logic [31:0]      arr_rdata,
  output logic             assoc_multi
);
  localparam int ENTRIES = 1 << IDX_W;

  logic [21:0] e_vpn  [ENTRIES];
  logic [7:0]  e_asid [ENTRIES];
  logic [18:0] e_ppn  [ENTRIES];
  logic [8:0]  e_flg  [ENTRIES];
  logic [3:0]  e_attr [ENTRIES];

  logic [31:0]      st_hi, st_lo;
  logic [3:0]       st_attr;
  logic [2:0]       mode_bits;
  logic [IDX_W-1:0] urc, urb;
  logic [5:0]       lru;

  function automatic logic [21:0] page_mask(input logic [8:0] f);
    case ({f[7], f[4]})
      2'b00:   page_mask = 22'h3FFFFF;
      2'b01:   page_mask = 22'h3FFFFC;
      2'b10:   page_mask = 22'h3FFFC0;
      default: page_mask = 22'h3FFC00;
    endcase
  endfunction

  logic             l_found, l_dup;
  logic [IDX_W-1:0] l_idx;
  logic             a_found, a_dup;
  logic [IDX_W-1:0] a_idx;

  always_comb begin
    l_found = 1'b0; l_dup = 1'b0; l_idx = '0;
    a_found = 1'b0; a_dup = 1'b0; a_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (e_flg[i][8] && (!lk_asid_chk || e_flg[i][1] || e_asid[i] == st_hi[7:0]) &&
          ((e_vpn[i] ^ lk_addr[31:10]) & page_mask(e_flg[i])) == '0) begin
        if (l_found) l_dup = 1'b1;
        else begin l_found = 1'b1; l_idx = IDX_W'(i); end
      end
      if ((e_flg[i][1] || e_asid[i] == st_hi[7:0]) &&
          ((e_vpn[i] ^ arr_wdata[31:10]) & page_mask(e_flg[i])) == '0) begin
        if (a_found) a_dup = 1'b1;
        else begin a_found = 1'b1; a_idx = IDX_W'(i); end
      end
    end
  end

  assign lk_hit   = lk_valid & l_found & ~l_dup;
  assign lk_miss  = lk_valid & ~l_found;
  assign lk_multi = lk_valid & l_dup;
  assign lk_index = l_idx;
  assign lk_ppn   = {3'b000, e_ppn[l_idx], 10'b0};
  assign lk_flags = e_flg[l_idx];
  assign lk_attr  = e_attr[l_idx];

  wire              ctl_wr   = reg_we && reg_sel == 2'd3;
  wire              assoc_wr = arr_en && arr_we && !arr_sel && arr_addr[7];
  wire [IDX_W-1:0]  a_ent    = arr_addr[8 +: IDX_W];
  wire [IDX_W:0]    urc_inc  = {1'b0, urc} + 1'b1;
  wire [IDX_W-1:0]  urc_next = (urc_inc[IDX_W] || urc_inc == {1'b0, urb}) ? '0 : urc_inc[IDX_W-1:0];

  assign assoc_multi = assoc_wr & a_dup;

  always_comb begin
    reg_rdata = '0;
    case (reg_sel)
      2'd0: reg_rdata = st_hi;
      2'd1: reg_rdata = st_lo;
      2'd2: reg_rdata[3:0] = st_attr;
      default: begin
        reg_rdata[0]            = mode_bits[0];
        reg_rdata[9:8]          = mode_bits[2:1];
        reg_rdata[10 +: IDX_W]  = urc;
        reg_rdata[18 +: IDX_W]  = urb;
        reg_rdata[31:26]        = lru;
      end
    endcase
  end

  always_comb begin
    if (!arr_sel)
      arr_rdata = {e_vpn[a_ent], e_flg[a_ent][2], e_flg[a_ent][8], e_asid[a_ent]};
    else if (arr_addr[23])
      arr_rdata = {28'b0, e_attr[a_ent]};
    else
      arr_rdata = {3'b000, e_ppn[a_ent], 1'b0, e_flg[a_ent]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_hi <= '0; st_lo <= '0; st_attr <= '0;
      mode_bits <= '0; urc <= '0; urb <= '0; lru <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        e_vpn[i] <= '0; e_asid[i] <= '0; e_ppn[i] <= '0;
        e_flg[i] <= '0; e_attr[i] <= '0;
      end
    end else begin
      if (reg_we) begin
        case (reg_sel)
          2'd0: st_hi   <= reg_wdata & 32'hFFFF_FCFF;
          2'd1: st_lo   <= reg_wdata & 32'h1FFF_FDFF;
          2'd2: st_attr <= reg_wdata[3:0];
          default: begin
            mode_bits <= {reg_wdata[9:8], reg_wdata[0]};
            urc       <= reg_wdata[10 +: IDX_W];
            urb       <= reg_wdata[18 +: IDX_W];
            lru       <= reg_wdata[31:26];
          end
        endcase
      end
      if (lk_valid && !ctl_wr) urc <= urc_next;
      if (ld_entry) begin
        e_vpn[urc]  <= st_hi[31:10];
        e_asid[urc] <= st_hi[7:0];
        e_ppn[urc]  <= st_lo[28:10];
        e_flg[urc]  <= st_lo[8:0];
        e_attr[urc] <= st_attr;
      end
      if (arr_en && arr_we) begin
        if (!arr_sel) begin
          if (arr_addr[7]) begin
            if (a_found && !a_dup) begin
              e_flg[a_idx][8] <= arr_wdata[8];
              e_flg[a_idx][2] <= arr_wdata[9];
            end
          end else begin
            e_vpn[a_ent]    <= arr_wdata[31:10];
            e_asid[a_ent]   <= arr_wdata[7:0];
            e_flg[a_ent][8] <= arr_wdata[8];
            e_flg[a_ent][2] <= arr_wdata[9];
          end
        end else if (arr_addr[23]) begin
          e_attr[a_ent] <= arr_wdata[3:0];
        end else begin
          e_ppn[a_ent] <= arr_wdata[28:10];
          e_flg[a_ent] <= arr_wdata[8:0];
        end
      end
      if (ctl_wr && reg_wdata[2])
        for (int i = 0; i < ENTRIES; i++) e_flg[i][8] <= 1'b0;
    end
  end
endmodule

// File: rtl/xlat_utlb_chk.sv
module xlat_utlb_chk #(
  parameter int IDX_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lk_valid,
  input logic             lk_hit,
  input logic             lk_miss,
  input logic             lk_multi,
  input logic             reg_we,
  input logic [1:0]       reg_sel,
  input logic [31:0]      reg_wdata,
  input logic             ld_entry,
  input logic [IDX_W-1:0] urc,
  input logic [IDX_W-1:0] urb
);
  wire ctl_wr = reg_we && reg_sel == 2'd3;

  AST_URC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && !ctl_wr) |=> (urc == '0 || urc == $past(urc) + 1'b1)); // R2
  AST_URC_SKIPS_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && !ctl_wr && urb != '0) |=> (urc != urb)); // R3
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |-> $countones({lk_hit, lk_miss, lk_multi}) == 1); // R6
  AST_LOAD_KEEPS_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_entry && !lk_valid && !ctl_wr) |=> (urc == $past(urc))); // R7
  AST_FLUSH_MISSES: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && reg_wdata[2]) |=> (!lk_valid || lk_miss)); // R12
endmodule

bind xlat_utlb xlat_utlb_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_hit(lk_hit),
  .lk_miss(lk_miss), .lk_multi(lk_multi), .reg_we(reg_we), .reg_sel(reg_sel),
  .reg_wdata(reg_wdata), .ld_entry(ld_entry), .urc(urc), .urb(urb)
);

// File: tb/xlat_utlb_test.sv
module xlat_utlb_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic lk_valid, lk_asid_chk, reg_we, ld_entry, arr_en, arr_we, arr_sel;
  logic [31:0] lk_addr, reg_wdata, arr_addr, arr_wdata;
  logic [1:0] reg_sel;
  logic lk_hit, lk_miss, lk_multi, assoc_multi;
  logic [5:0] lk_index;
  logic [31:0] lk_ppn, reg_rdata, arr_rdata;
  logic [8:0] lk_flags;
  logic [3:0] lk_attr;

  always #4 clk = ~clk;

  xlat_utlb uut (.*);

  int n_chk = 0, n_fail = 0;
  logic [31:0] m_vpnf [64], m_ppnf [64];
  logic [7:0]  m_asid [64];
  logic [8:0]  m_flg  [64];
  logic [3:0]  m_attr [64];
  logic [31:0] m_hi, m_lo, m_cb;
  logic [3:0]  m_sattr;
  int m_urc, m_urb, m_lru;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    lk_valid = 0; lk_asid_chk = 0; lk_addr = 0; reg_we = 0; reg_sel = 0; reg_wdata = 0;
    ld_entry = 0; arr_en = 0; arr_we = 0; arr_sel = 0; arr_addr = 0; arr_wdata = 0;
  endtask

  function automatic bit b_match(int i, logic [31:0] a, logic [7:0] asid, bit chk_asid, bit need_v);
    int pb;
    case ({m_flg[i][7], m_flg[i][4]})
      2'b00: pb = 10; 2'b01: pb = 12; 2'b10: pb = 16; default: pb = 20;
    endcase
    if (need_v && !m_flg[i][8]) return 0;
    if (chk_asid && !m_flg[i][1] && m_asid[i] != asid) return 0;
    return ((a ^ m_vpnf[i]) >> pb) == 0;
  endfunction

  function automatic logic [31:0] exp_ctl();
    return m_cb | (m_urc << 10) | (m_urb << 18) | (m_lru << 26);
  endfunction

  task automatic do_lookup(logic [31:0] a, bit c);
    int cnt = 0, idx = 0;
    string tag;
    @(negedge clk); idle(); lk_valid = 1; lk_addr = a; lk_asid_chk = c; #2;
    for (int i = 0; i < 64; i++)
      if (b_match(i, a, m_hi[7:0], c, 1)) begin if (cnt == 0) idx = i; cnt++; end
    tag = (cnt > 1) ? "R6 multi" : (c ? "R4 asid-match" : "R5 no-asid-match");
    chk(tag, {29'b0, lk_hit, lk_miss, lk_multi}, {29'b0, cnt == 1, cnt == 0, cnt > 1});
    if (cnt == 1) begin
      chk("R4 index", lk_index, idx);
      chk("R4 page", lk_ppn, m_ppnf[idx]);
      chk("R4 flags", lk_flags, m_flg[idx]);
      chk("R4 attr", lk_attr, m_attr[idx]);
    end
    @(posedge clk);
    m_urc = m_urc + 1;
    if (m_urc == m_urb || m_urc == 64) m_urc = 0;
  endtask

  task automatic do_reg_wr(logic [1:0] s, logic [31:0] d);
    @(negedge clk); idle(); reg_we = 1; reg_sel = s; reg_wdata = d;
    @(posedge clk);
    case (s)
      2'd0: m_hi = d & 32'hFFFF_FCFF;
      2'd1: m_lo = d & 32'h1FFF_FDFF;
      2'd2: m_sattr = d[3:0];
      default: begin
        m_cb = d & 32'h0000_0301; m_urc = d[15:10]; m_urb = d[23:18]; m_lru = d[31:26];
        if (d[2]) for (int i = 0; i < 64; i++) m_flg[i][8] = 0;
      end
    endcase
  endtask

  task automatic do_reg_rd(logic [1:0] s, string tag);
    logic [31:0] e;
    @(negedge clk); idle(); reg_sel = s; #2;
    case (s)
      2'd0: e = m_hi; 2'd1: e = m_lo; 2'd2: e = {28'b0, m_sattr}; default: e = exp_ctl();
    endcase
    chk(tag, reg_rdata, e);
  endtask

  task automatic do_load();
    @(negedge clk); idle(); ld_entry = 1;
    @(posedge clk);
    m_vpnf[m_urc] = m_hi & 32'hFFFF_FC00; m_asid[m_urc] = m_hi[7:0];
    m_ppnf[m_urc] = m_lo & 32'h1FFF_FC00; m_flg[m_urc] = m_lo[8:0]; m_attr[m_urc] = m_sattr;
  endtask

  task automatic do_arr_wr(bit s, logic [31:0] a, logic [31:0] d);
    int cnt = 0, idx = 0, e = a[13:8];
    @(negedge clk); idle(); arr_en = 1; arr_we = 1; arr_sel = s; arr_addr = a; arr_wdata = d; #2;
    if (!s && a[7]) begin
      for (int i = 0; i < 64; i++)
        if (b_match(i, d, m_hi[7:0], 1, 0)) begin if (cnt == 0) idx = i; cnt++; end
      chk("R10 assoc collision flag", {31'b0, assoc_multi}, {31'b0, cnt > 1});
    end
    @(posedge clk);
    if (!s) begin
      if (a[7]) begin
        if (cnt == 1) begin m_flg[idx][8] = d[8]; m_flg[idx][2] = d[9]; end
      end else begin
        m_vpnf[e] = d & 32'hFFFF_FC00; m_asid[e] = d[7:0]; m_flg[e][8] = d[8]; m_flg[e][2] = d[9];
      end
    end else if (a[23]) m_attr[e] = d[3:0];
    else begin m_ppnf[e] = d & 32'h1FFF_FC00; m_flg[e] = d[8:0]; end
  endtask

  task automatic do_arr_rd(bit s, logic [31:0] a, string tag);
    int e = a[13:8];
    logic [31:0] x;
    @(negedge clk); idle(); arr_en = 1; arr_sel = s; arr_addr = a; #2;
    if (!s) x = m_vpnf[e] | (32'(m_flg[e][2]) << 9) | (32'(m_flg[e][8]) << 8) | m_asid[e];
    else if (a[23]) x = {28'b0, m_attr[e]};
    else x = m_ppnf[e] | m_flg[e];
    chk(tag, arr_rdata, x);
  endtask

  function automatic logic [31:0] pool(int k);
    case (k % 6)
      0: return 32'h0000_0000; 1: return 32'h0000_1000; 2: return 32'h0001_0000;
      3: return 32'h0010_0000; 4: return 32'h7FF0_0000; default: return 32'h4000_4400;
    endcase
  endfunction

  initial begin
    #(8 * 200000);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    idle();
    for (int i = 0; i < 64; i++) begin
      m_vpnf[i] = 0; m_ppnf[i] = 0; m_asid[i] = 0; m_flg[i] = 0; m_attr[i] = 0;
    end
    m_hi = 0; m_lo = 0; m_cb = 0; m_sattr = 0; m_urc = 0; m_urb = 0; m_lru = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;

    // R1 reset state
    for (int s = 0; s < 4; s++) do_reg_rd(2'(s), "R1 register after reset");
    do_arr_rd(0, 32'h0000_0500, "R1 tag word after reset");
    do_lookup(32'h0000_0000, 0);

    // R13 staging masks
    do_reg_wr(0, 32'hFFFF_FFFF); do_reg_rd(0, "R13 staged tag mask");
    do_reg_wr(1, 32'hFFFF_FFFF); do_reg_rd(1, "R13 staged page mask");
    do_reg_wr(2, 32'hFFFF_FFFF); do_reg_rd(2, "R13 attribute mask");

    // R12 control load and readback, R2/R3 wrap at boundary
    do_reg_wr(3, (32'd42 << 26) | (32'd5 << 18) | (32'd3 << 10) | 32'h0000_0301);
    do_reg_rd(3, "R12 control readback");
    do_lookup(32'h1234_0000, 1); do_reg_rd(3, "R2 pointer advances on miss");
    do_lookup(32'h1234_0000, 1); do_reg_rd(3, "R3 pointer wraps at boundary");
    chk("R3 pointer zero at boundary", reg_rdata[15:10], 0);
    do_reg_wr(3, 32'd62 << 10);
    do_lookup(32'h0, 0); do_lookup(32'h0, 0); do_reg_rd(3, "R3 wrap at 64");
    chk("R3 pointer zero after 63", reg_rdata[15:10], 0);

    // R7 load entry at pointer 7
    do_reg_wr(0, 32'h1234_5C01);
    do_reg_wr(1, 32'h0ABC_D000 | 32'h1F4);
    do_reg_wr(2, 32'h9);
    do_reg_wr(3, 32'd7 << 10);
    do_load();
    do_reg_rd(3, "R7 pointer unchanged by load");
    chk("R7 pointer value", reg_rdata[15:10], 7);
    do_arr_rd(0, 32'h0000_0700, "R7 loaded tag word");
    do_arr_rd(1, 32'h0000_0700, "R11 loaded data word");
    do_arr_rd(1, 32'h0080_0700, "R11 loaded attribute");
    do_lookup(32'h1234_5ABC, 1);
    chk("R4 hit on loaded page", lk_hit, 1);

    // R4/R5 address-space handling
    do_reg_wr(0, 32'h0000_0002);
    do_lookup(32'h1234_5000, 1);
    do_lookup(32'h1234_5000, 0);

    // R8 direct tag write, R6 multi-hit
    do_arr_wr(0, 32'h0000_0900, 32'h1234_5102);
    do_arr_wr(1, 32'h0000_0900, 32'h0000_0110);
    do_arr_rd(0, 32'h0000_0900, "R8 direct tag word");
    do_lookup(32'h1234_5000, 0);
    chk("R6 multi-hit", lk_multi, 1);

    // R9 associative write single match, no match
    do_arr_wr(0, 32'h0000_0080, 32'h1234_5200);
    do_arr_rd(0, 32'h0000_0900, "R9 associative update");
    do_arr_wr(0, 32'h0000_0080, 32'h5555_5300);
    do_arr_rd(0, 32'h0000_0900, "R9 associative miss leaves entry");
    // R10 collision
    do_arr_wr(0, 32'h0000_0900, 32'h1234_5101);
    do_reg_wr(0, 32'h0000_0001);
    do_arr_wr(0, 32'h0000_0080, 32'h1234_5000);
    do_arr_rd(0, 32'h0000_0700, "R10 entry 7 unchanged");
    do_arr_rd(0, 32'h0000_0900, "R10 entry 9 unchanged");

    // R11 attribute write
    do_arr_wr(1, 32'h0080_0900, 32'hFFFF_FFF6);
    do_arr_rd(1, 32'h0080_0900, "R11 attribute write");
    do_arr_rd(1, 32'h0000_0900, "R11 data word after attribute write");

    // R12 invalidate all
    do_reg_wr(3, 32'h0000_0004);
    do_lookup(32'h1234_5000, 0);
    chk("R12 miss after invalidate", lk_miss, 1);

    // random mix
    for (int n = 0; n < 4000; n++) begin
      int r = $urandom % 12;
      logic [31:0] v = pool($urandom) | ($urandom % 2 ? ($urandom & 32'h3FF) : ($urandom & 32'hF_FFFF));
      if (r < 4) do_lookup(v, $urandom % 2);
      else if (r == 4) do_reg_wr(0, (v & 32'hFFFF_FC00) | 32'(1 + $urandom % 2));
      else if (r == 5) do_reg_wr(1, ($urandom & 32'h1FFF_FC00) | ($urandom % 4 ? 32'h100 : 0) | ($urandom & 32'hFF));
      else if (r == 6) do_load();
      else if (r == 7) do_arr_wr(0, {18'b0, 6'($urandom), 8'b0}, (v & 32'hFFFF_FC00) | ($urandom & 32'h300) | 32'(1 + $urandom % 2));
      else if (r == 8) do_arr_wr(1, {8'b0, 1'($urandom), 9'b0, 6'($urandom), 8'b0}, $urandom);
      else if (r == 9) do_arr_wr(0, 32'h0000_0080, (v & 32'hFFFF_FC00) | ($urandom & 32'h300));
      else if (r == 10) do_arr_rd($urandom % 2, {8'b0, 1'($urandom), 9'b0, 6'($urandom), 8'b0}, "R8 R11 random array read");
      else begin
        if ($urandom % 8 == 0) do_reg_wr(3, $urandom & ~32'h4 | ($urandom % 10 == 0 ? 32'h4 : 0));
        else do_reg_rd(2'($urandom), "R2 R12 R13 random register read");
      end
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule